// File: doc/BRIEF.md
# Superpage promotion monitor

This block watches the stream of translation-miss events coming out of an address-translation cache and decides when a run of base pages is worth merging into one large page. The virtual address space is cut into aligned regions of 16 consecutive base pages. The monitor keeps a small set of trackers, each of which holds one region and counts how many misses that region has caused. When the miss count of a region reaches the programmed copy-cost ratio N, the block raises a one-cycle promote pulse with the region's first page number. Software or a page-walk engine then carries out the copy and updates the page table.

The trigger follows the break-even rent-or-buy rule. Each miss costs one unit and a promotion costs N units, so the block buys only once it has paid as much in rent as the purchase would cost. This keeps the total spend within a factor of two of the best possible choice, a bound that a plain hot-page counter does not give. An untracked region takes a tracker chosen by a round-robin pointer. A clear input flushes all trackers at once.

Each tracker is a two-state machine. In SLOT_FREE it holds no region. The transition alloc moves it to SLOT_COUNT. Inside SLOT_COUNT, bump stays in the state and adds one to the count, and evict also stays in the state while loading a new region. The transitions fire and flush both return it to SLOT_FREE. The output stage has two states. OUT_IDLE goes to OUT_PULSE on fire. OUT_PULSE holds for exactly one cycle and then returns through done, or stays in OUT_PULSE if another fire follows in the next cycle.

Top module: `sppm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `promote` is 0, `promote_base` is 0, and every tracker is free.
- R2: A region is `miss_vpn` with its low 4 bits removed. `promote_base` carries that region shifted left by 4, so its low 4 bits are always zero.
- R3: Each accepted miss to a tracked region adds one to that region's count. When the count after the add is at least `copy_cost`, `promote` is 1 in the cycle after the clock edge that accepted that miss, and only in that cycle.
- R4: A tracker that fires is freed. A later miss to the same region restarts its count at 1.
- R5: A miss to an untracked region loads the tracker selected by a round-robin pointer and sets its count to 1, replacing any region held there. The pointer is 0 after reset or clear, moves on by one with each such load, and wraps after tracker 7.
- R6: With `copy_cost` equal to 1, a miss to an untracked region promotes at once. It occupies no tracker and leaves the pointer where it was.
- R7: With `copy_cost` equal to 0, promotion is disabled. Misses still allocate and count.
- R8: Counts saturate at 1023. A change to `copy_cost` takes effect on the next miss, which is compared with at-least against the new value.
- R9: `clr` frees every tracker, returns the pointer to 0, drops a miss presented in the same cycle, and forces `promote` to 0 in the next cycle.
- R10: Up to 8 regions are counted at the same time, with misses interleaved in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous flush of all trackers |
| miss_valid | input | 1 | A translation miss is presented this cycle |
| miss_vpn | input | 20 | Virtual page number of the miss |
| copy_cost | input | 10 | Copy-cost ratio N; 0 disables promotion |
| promote | output | 1 | One-cycle promotion request |
| promote_base | output | 20 | First page number of the promoted region |

## Verification
Wrong tracker state reaches the ports only through `promote`. A count that is off by one shifts the pulse by one miss. A tracker that is not freed, or a pointer that stepped wrongly, shows up only several misses later, when an evicted or retained region fires at the wrong time. For this reason the eviction and N=1 tests fill all eight trackers and then probe the oldest one. Saturation errors stay hidden until more than a thousand misses have arrived, so one test drives that many before it lowers the threshold.

// File: rtl/sppm_pkg.sv
package sppm_pkg;
    typedef enum logic {
        SLOT_FREE  = 1'b0,
        SLOT_COUNT = 1'b1
    } slot_state_t;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_PULSE = 1'b1
    } out_state_t;
endpackage

// File: rtl/sppm_rr.sv
module sppm_rr #(
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [SLOTS-1:0] sel_o
);
    localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (clr_i)
            ptr_q <= '0;
        else if (adv_i)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_comb begin
        sel_o = '0;
        sel_o[ptr_q] = 1'b1;
    end
endmodule

// File: rtl/sppm_slot.sv
module sppm_slot
    import sppm_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int COST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              evt_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [COST_W-1:0] thresh_i,
    input  logic              alloc_i,
    output logic              hit_o,
    output logic              fire_o
);
    localparam logic [COST_W-1:0] CNT_MAX = '1;

    slot_state_t       st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [COST_W-1:0] cnt_q, cnt_nx;
    logic              bump;

    assign hit_o  = (st_q == SLOT_COUNT) && (tag_q == tag_i);
    assign bump   = evt_i && hit_o;
    assign cnt_nx = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    assign fire_o = bump && (thresh_i != '0) && (cnt_nx >= thresh_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE:  if (!clr_i && alloc_i) st_d = SLOT_COUNT;
            SLOT_COUNT: if (clr_i || fire_o)   st_d = SLOT_FREE;
            default:    st_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= SLOT_FREE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            cnt_q <= '0;
        end else if (alloc_i && !clr_i) begin
            tag_q <= tag_i;
            cnt_q <= COST_W'(1);
        end else if (bump && !fire_o) begin
            cnt_q <= cnt_nx;
        end
    end

    AST_FREED_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (st_q == SLOT_FREE)); // R4
    AST_ALLOC_STARTS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !clr_i) |=> (cnt_q == COST_W'(1))); // R5
endmodule

// File: rtl/sppm_top.sv
module sppm_top
    import sppm_pkg::*;
#(
    parameter int VPN_W    = 20,
    parameter int OFS_BITS = 4,
    parameter int TRACKERS = 8,
    parameter int COST_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [COST_W-1:0] copy_cost,
    output logic              promote,
    output logic [VPN_W-1:0]  promote_base
);
    localparam int TAG_W = VPN_W - OFS_BITS;

    logic [TAG_W-1:0]    tag;
    logic                evt;
    logic [TRACKERS-1:0] hit, fire, sel, alloc;
    logic                any_hit, alloc_fire, alloc_go, fire_any;
    out_state_t          out_q, out_d;
    logic [VPN_W-1:0]    base_q;

    assign tag        = miss_vpn[VPN_W-1:OFS_BITS];
    assign evt        = miss_valid && !clr;
    assign any_hit    = |hit;
    assign alloc_fire = evt && !any_hit && (copy_cost == COST_W'(1));
    assign alloc_go   = evt && !any_hit && (copy_cost != COST_W'(1));
    assign alloc      = alloc_go ? sel : '0;
    assign fire_any   = (|fire) || alloc_fire;

    sppm_rr #(.SLOTS(TRACKERS)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .adv_i (alloc_go),
        .sel_o (sel)
    );

    for (genvar g = 0; g < TRACKERS; g++) begin : g_slot
        sppm_slot #(.TAG_W(TAG_W), .COST_W(COST_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .evt_i    (evt),
            .tag_i    (tag),
            .thresh_i (copy_cost),
            .alloc_i  (alloc[g]),
            .hit_o    (hit[g]),
            .fire_o   (fire[g])
        );
    end

    always_comb begin
        out_d = OUT_IDLE;
        unique case (out_q)
            OUT_IDLE:  if (fire_any) out_d = OUT_PULSE;
            OUT_PULSE: if (fire_any) out_d = OUT_PULSE;
            default:   out_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= OUT_IDLE;
            base_q <= '0;
        end else begin
            out_q <= out_d;
            if (fire_any)
                base_q <= {tag, {OFS_BITS{1'b0}}};
        end
    end

    assign promote      = (out_q == OUT_PULSE);
    assign promote_base = base_q;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R10
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_cost == '0) |=> !promote); // R7
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !promote); // R9
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        promote |-> (promote_base[OFS_BITS-1:0] == '0)); // R2
endmodule

// File: tb/sim_sppm_top.sv
module sim_sppm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic [9:0]  copy_cost = '0;
    logic        promote;
    logic [19:0] promote_base;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sppm_top u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .miss_valid(miss_valid),
        .miss_vpn(miss_vpn), .copy_cost(copy_cost),
        .promote(promote), .promote_base(promote_base)
    );

    typedef struct packed {
        logic        c;
        logic        v;
        logic [19:0] vpn;
        logic [9:0]  n;
        logic        ep;
        logic [19:0] eb;
    } vec_t;

    // R3 R4 R5 R10 interleaved counting with N=3
    localparam vec_t TBL [10] = '{
        '{1'b0, 1'b1, 20'd64, 10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b1, 20'd70, 10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b1, 20'd79, 10'd3, 1'b1, 20'd64},
        '{1'b0, 1'b1, 20'd65, 10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b0, 20'd0,  10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b1, 20'd80, 10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b1, 20'd66, 10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b1, 20'd81, 10'd3, 1'b0, 20'd0},
        '{1'b0, 1'b1, 20'd67, 10'd3, 1'b1, 20'd64},
        '{1'b0, 1'b1, 20'd95, 10'd3, 1'b1, 20'd80}
    };

    task automatic cyc(input logic c, input logic v, input logic [19:0] vpn,
                       input logic [9:0] n);
        clr = c; miss_valid = v; miss_vpn = vpn; copy_cost = n;
        @(negedge clk);
        clr = 1'b0; miss_valid = 1'b0;
    endtask

    task automatic chk(input string req, input logic ep, input logic [19:0] eb);
        checks++;
        if (promote !== ep || (ep && promote_base !== eb)) begin
            errs++;
            $display("FAIL %s: promote=%0b base=%0d expected promote=%0b base=%0d",
                     req, promote, promote_base, ep, eb);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        checks++;
        if (promote !== 1'b0 || promote_base !== 20'd0) begin
            errs++;
            $display("FAIL R1: promote=%0b base=%0d expected 0 0", promote, promote_base);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 1'b0, 20'd0);

        foreach (TBL[i]) begin
            cyc(TBL[i].c, TBL[i].v, TBL[i].vpn, TBL[i].n);
            chk("R3/R10 table", TBL[i].ep, TBL[i].eb);
        end

        // R5 eviction: 9 regions, the 9th replaces region 0 in slot 0
        cyc(1'b1, 1'b0, 20'd0, 10'd3);
        for (int k = 0; k < 9; k++) cyc(1'b0, 1'b1, 20'(16 * (100 + k)), 10'd3);
        cyc(1'b0, 1'b1, 20'(16 * 108 + 5), 10'd3);
        chk("R5 newest kept", 1'b0, 20'd0);
        cyc(1'b0, 1'b1, 20'(16 * 108 + 9), 10'd3);
        chk("R5 newest fires", 1'b1, 20'(16 * 108));
        cyc(1'b0, 1'b1, 20'(16 * 100), 10'd3);
        cyc(1'b0, 1'b1, 20'(16 * 100), 10'd3);
        chk("R4 evicted restarts at 1", 1'b0, 20'd0);
        cyc(1'b0, 1'b1, 20'(16 * 100), 10'd3);
        chk("R4 evicted region fires on third", 1'b1, 20'(16 * 100));
        cyc(1'b0, 1'b1, 20'(16 * 101), 10'd3);
        cyc(1'b0, 1'b1, 20'(16 * 101), 10'd3);
        chk("R5 region in slot 1 was replaced", 1'b0, 20'd0);

        // R6: N=1 fires at once and leaves the pointer alone
        cyc(1'b1, 1'b0, 20'd0, 10'd3);
        cyc(1'b0, 1'b1, 20'd205, 10'd1);
        chk("R6 immediate fire", 1'b1, 20'd192);
        for (int k = 0; k < 8; k++) cyc(1'b0, 1'b1, 20'(16 * (300 + k)), 10'd3);
        cyc(1'b0, 1'b1, 20'(16 * 300), 10'd3);
        cyc(1'b0, 1'b1, 20'(16 * 300), 10'd3);
        chk("R6 pointer unchanged", 1'b1, 20'(16 * 300));

        // R9: clear flushes counts and drops a same-cycle miss
        cyc(1'b1, 1'b0, 20'd0, 10'd3);
        cyc(1'b0, 1'b1, 20'd512, 10'd3);
        cyc(1'b0, 1'b1, 20'd512, 10'd3);
        cyc(1'b1, 1'b1, 20'd512, 10'd3);
        chk("R9 clr suppresses", 1'b0, 20'd0);
        cyc(1'b0, 1'b1, 20'd512, 10'd3);
        cyc(1'b0, 1'b1, 20'd512, 10'd3);
        chk("R9 count restarted", 1'b0, 20'd0);
        cyc(1'b0, 1'b1, 20'd512, 10'd3);
        chk("R9 fires after three", 1'b1, 20'd512);

        // R7 and R8: N=0 never fires, count saturates at 1023
        cyc(1'b1, 1'b0, 20'd0, 10'd0);
        begin
            int seen = 0;
            for (int k = 0; k < 1030; k++) begin
                cyc(1'b0, 1'b1, 20'd4096, 10'd0);
                if (promote !== 1'b0) seen++;
            end
            checks++;
            if (seen != 0) begin
                errs++;
                $display("FAIL R7: promote pulses=%0d expected 0", seen);
            end
        end
        cyc(1'b0, 1'b1, 20'd4097, 10'd1023);
        chk("R8 saturated count meets 1023", 1'b1, 20'd4096);

        // R8: lowering N below the current count fires on the next miss
        cyc(1'b0, 1'b1, 20'd8192, 10'd9);
        cyc(1'b0, 1'b1, 20'd8192, 10'd9);
        cyc(1'b0, 1'b1, 20'd8192, 10'd9);
        chk("R8 below N", 1'b0, 20'd0);
        cyc(1'b0, 1'b1, 20'd8192, 10'd2);
        chk("R8 lowered N", 1'b1, 20'd8192);
        cyc(1'b0, 1'b0, 20'd0, 10'd2);
        chk("R3 pulse is one cycle", 1'b0, 20'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule